// File: doc/BRIEF.md
# Lane-Folded Bus Link with Optional Delta Coding

This block stands in for a wide parallel on-chip bus. A word of `LANES*DEGREE` bits enters on the sending side and is carried over only `LANES` wires. Each wire moves `DEGREE` bits in turn, one per fast-clock cycle. A receiving side collects the slices and rebuilds the word. With the defaults (32 lanes, degree 2) a 64-bit word crosses 32 wires in two cycles. The sender therefore takes at most one word every `DEGREE` cycles, which matches the throughput of a parallel bus clocked `DEGREE` times slower.

A delta mode can be switched on, word by word. In that mode the sender puts the difference from the previously accepted word on the wires instead of the raw word. The receiver adds each difference back onto its last rebuilt word. Address streams that step by small amounts then carry mostly zero bits, which cuts wire toggling. Data traffic should leave the mode off.

The mode flag travels on one extra wire beside the lanes, so both ends use the same setting for every word. A start wire marks the first slice of each word.

Top module: `lane_fold_link`

## Requirements
- R1: While reset is asserted and right after it, `in_ready` is 1, and `out_valid`, `lane_start` and every bit of `lane_data` are 0.
- R2: A word is accepted at a clock edge where `in_valid` and `in_ready` are both 1. In the k-th cycle after that edge (k = 0 .. DEGREE-1), `lane_data` carries bits k*LANES .. k*LANES+LANES-1 of the coded word, so lane i carries bits i, i+LANES, i+2*LANES and so on, lowest slice first. `lane_start` is 1 only in the k = 0 cycle. When no transfer is in progress, `lane_data` is 0.
- R3: After an acceptance, `in_ready` stays 0 for DEGREE-1 cycles and returns to 1 in the cycle that shows the last slice. Words can therefore be accepted back to back, one every DEGREE cycles.
- R4: An input offered while `in_ready` is 0 is ignored. It changes neither the slices on the lanes nor any later output word.
- R5: With `delta_en` at 0 when a word is accepted, the coded word equals the input word, and `out_word` equals the input word.
- R6: With `delta_en` at 1 when a word is accepted, the coded word is (input word minus previously accepted word) modulo 2^(LANES*DEGREE), `lane_delta` is 1 during the transfer, and `out_word` still equals the input word.
- R7: After reset, the previous-word state on both sides is zero, so the first word accepted in delta mode appears on the lanes unchanged.
- R8: Every accepted word becomes the previous word for the next one, whatever mode it used. A delta-coded word that follows a raw word is therefore taken relative to that raw word.
- R9: `delta_en` is sampled only at the acceptance edge. Changing it during a transfer does not alter the word in flight or `lane_delta`.
- R10: `out_valid` is 1 for exactly one cycle per accepted word: the cycle after the edge DEGREE cycles past the acceptance edge. `out_word` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock (serial rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| delta_en | input | 1 | Delta coding for the word being accepted |
| in_valid | input | 1 | Sender word is offered |
| in_word | input | LANES*DEGREE | Sender parallel word |
| in_ready | output | 1 | Sender can accept a word at the next edge |
| lane_data | output | LANES | Serial lane wires |
| lane_start | output | 1 | First slice of a word is on the lanes |
| lane_delta | output | 1 | Mode wire for the word in flight |
| out_valid | output | 1 | Rebuilt word present for one cycle |
| out_word | output | LANES*DEGREE | Rebuilt parallel word |

## Verification
The sender's previous word and the receiver's rebuilt word are hidden state, and an error in either stays silent as long as delta mode is off. Once a delta-coded word follows, the error shows up as a wrong `out_word` or wrong lane slices. The bench therefore interleaves raw and delta words and runs a wraparound step. A wrong slice index or phase count shows up at once, in the same cycle, as a misplaced lane slice, a misplaced start flag or a wrong `in_ready`. A bad receiver phase moves `out_valid` away from its cycle, DEGREE cycles after acceptance.

// File: rtl/lfl_pkg.sv
package lfl_pkg;
  // Index width for a slice counter over 'count' positions.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/lfl_delta_codec.sv
// Delta coder: subtracts (RESTORE=0) or adds back (RESTORE=1) the base word.
module lfl_delta_codec #(
  parameter int WIDTH   = 64,
  parameter bit RESTORE = 1'b0
) (
  input  logic [WIDTH-1:0] base,
  input  logic [WIDTH-1:0] value,
  input  logic             enable,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] folded;

  generate
    if (RESTORE) begin : g_restore
      assign folded = value + base;
    end else begin : g_encode
      assign folded = value - base;
    end
  endgenerate

  assign result = enable ? folded : value;
endmodule

// File: rtl/lfl_slice_ctr.sv
// Slice phase counter: runs 0..DEGREE-1 after a start pulse, then idles.
module lfl_slice_ctr #(
  parameter int DEGREE = 2,
  localparam int IW    = lfl_pkg::idx_width(DEGREE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [IW-1:0] idx,
  output logic          active,
  output logic          last
);
  logic [IW-1:0] idx_q, idx_d;
  logic          active_q, active_d;

  assign last = active_q && (idx_q == IW'(DEGREE - 1));

  always_comb begin
    idx_d    = idx_q;
    active_d = active_q;
    if (start) begin
      idx_d    = '0;
      active_d = 1'b1;
    end else if (last) begin
      idx_d    = '0;
      active_d = 1'b0;
    end else if (active_q) begin
      idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      active_q <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      active_q <= active_d;
    end
  end

  assign idx    = idx_q;
  assign active = active_q;
endmodule

// File: rtl/lfl_tx.sv
// Sending side: codes the accepted word and emits one lane slice per cycle.
module lfl_tx #(
  parameter int LANES  = 32,
  parameter int DEGREE = 2,
  localparam int WORD  = LANES * DEGREE,
  localparam int IW    = lfl_pkg::idx_width(DEGREE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             delta_en,
  input  logic             in_valid,
  input  logic [WORD-1:0]  in_word,
  output logic             in_ready,
  output logic [LANES-1:0] lane_data,
  output logic             lane_start,
  output logic             lane_delta
);
  logic [IW-1:0]    idx;
  logic             active, last, accept;
  logic [WORD-1:0]  code_w;
  logic [WORD-1:0]  code_q, code_d;
  logic [WORD-1:0]  prev_q, prev_d;
  logic             mode_q, mode_d;
  logic [LANES-1:0] slice;

  assign in_ready = !active || last;
  assign accept   = in_valid && in_ready;

  lfl_slice_ctr #(.DEGREE(DEGREE)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .idx    (idx),
    .active (active),
    .last   (last)
  );

  lfl_delta_codec #(.WIDTH(WORD), .RESTORE(1'b0)) u_enc (
    .base   (prev_q),
    .value  (in_word),
    .enable (delta_en),
    .result (code_w)
  );

  always_comb begin
    code_d = code_q;
    prev_d = prev_q;
    mode_d = mode_q;
    if (accept) begin
      code_d = code_w;
      prev_d = in_word;
      mode_d = delta_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      prev_q <= '0;
      mode_q <= 1'b0;
    end else if (accept) begin
      code_q <= code_d;
      prev_q <= prev_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    slice = '0;
    for (int k = 0; k < DEGREE; k++) begin
      if (idx == IW'(k)) slice = code_q[k*LANES +: LANES];
    end
  end

  assign lane_data  = active ? slice : '0;
  assign lane_start = active && (idx == '0);
  assign lane_delta = mode_q;
endmodule

// File: rtl/lfl_rx.sv
// Receiving side: gathers slices, restores delta-coded words, flags each word.
module lfl_rx #(
  parameter int LANES  = 32,
  parameter int DEGREE = 2,
  localparam int WORD  = LANES * DEGREE,
  localparam int IW    = lfl_pkg::idx_width(DEGREE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_data,
  input  logic             lane_start,
  input  logic             lane_delta,
  output logic             out_valid,
  output logic [WORD-1:0]  out_word
);
  logic [WORD-1:0] acc_q, acc_d;
  logic [WORD-1:0] recon_q, recon_d;
  logic [WORD-1:0] word_q, word_d;
  logic [WORD-1:0] restored;
  logic [IW-1:0]   idx_q, idx_d, slot;
  logic            busy_q, busy_d;
  logic            mode_q, mode_d, eff_mode;
  logic            valid_d, valid_q;
  logic            taking, finish;

  assign slot     = lane_start ? '0 : idx_q;
  assign taking   = lane_start || busy_q;
  assign finish   = taking && (slot == IW'(DEGREE - 1));
  assign eff_mode = lane_start ? lane_delta : mode_q;

  always_comb begin
    acc_d = acc_q;
    for (int k = 0; k < DEGREE; k++) begin
      if (taking && slot == IW'(k)) acc_d[k*LANES +: LANES] = lane_data;
    end
  end

  lfl_delta_codec #(.WIDTH(WORD), .RESTORE(1'b1)) u_dec (
    .base   (recon_q),
    .value  (acc_d),
    .enable (eff_mode),
    .result (restored)
  );

  always_comb begin
    idx_d   = idx_q;
    busy_d  = busy_q;
    mode_d  = mode_q;
    recon_d = recon_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (lane_start) mode_d = lane_delta;
    if (taking) begin
      busy_d = !finish;
      idx_d  = finish ? '0 : slot + 1'b1;
    end
    if (finish) begin
      recon_d = restored;
      word_d  = restored;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (taking) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recon_q <= '0;
      word_q  <= '0;
    end else if (finish) begin
      recon_q <= recon_d;
      word_q  <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      mode_q  <= mode_d;
      valid_q <= valid_d;
    end
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;
endmodule

// File: rtl/lane_fold_link.sv
// Top: sender and receiver joined by the lane, start and mode wires.
module lane_fold_link #(
  parameter int LANES  = 32,
  parameter int DEGREE = 2,
  localparam int WORD  = LANES * DEGREE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             delta_en,
  input  logic             in_valid,
  input  logic [WORD-1:0]  in_word,
  output logic             in_ready,
  output logic [LANES-1:0] lane_data,
  output logic             lane_start,
  output logic             lane_delta,
  output logic             out_valid,
  output logic [WORD-1:0]  out_word
);
  lfl_tx #(.LANES(LANES), .DEGREE(DEGREE)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .delta_en   (delta_en),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_ready   (in_ready),
    .lane_data  (lane_data),
    .lane_start (lane_start),
    .lane_delta (lane_delta)
  );

  lfl_rx #(.LANES(LANES), .DEGREE(DEGREE)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_data  (lane_data),
    .lane_start (lane_start),
    .lane_delta (lane_delta),
    .out_valid  (out_valid),
    .out_word   (out_word)
  );
endmodule

// File: rtl/lane_fold_link_checker.sv
module lane_fold_link_checker #(
  parameter int DEGREE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic lane_start,
  input logic lane_delta,
  input logic out_valid
);
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (DEGREE > 1 && in_valid && in_ready) |=> !in_ready);

  assert_start_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> lane_start);

  assert_no_start_when_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !lane_start);

  assert_mode_steady_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_start |-> $stable(lane_delta));

  assert_single_pulse_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (DEGREE > 1 && out_valid) |=> !out_valid);
endmodule

bind lane_fold_link lane_fold_link_checker #(.DEGREE(DEGREE)) u_lfl_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .lane_start (lane_start),
  .lane_delta (lane_delta),
  .out_valid  (out_valid)
);

// File: tb/lane_fold_link_bench.sv
`timescale 1ns/1ps
module lane_fold_link_bench;
  localparam int M = 32;
  localparam int N = 2;
  localparam int W = M * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         delta_en = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         in_ready, lane_start, lane_delta, out_valid;
  logic [M-1:0] lane_data;
  logic [W-1:0] out_word;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_acc = -1000;
  logic [W-1:0] prev_word = '0;

  logic [M-1:0] exp_lane [int];
  logic         exp_start [int];
  logic         exp_mode [int];
  logic [W-1:0] exp_out [int];

  always #10 clk = ~clk;

  lane_fold_link #(.LANES(M), .DEGREE(N)) u_lane_fold_link (
    .clk(clk), .rst_n(rst_n), .delta_en(delta_en), .in_valid(in_valid),
    .in_word(in_word), .in_ready(in_ready), .lane_data(lane_data),
    .lane_start(lane_start), .lane_delta(lane_delta),
    .out_valid(out_valid), .out_word(out_word)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_now();
    chk("R3 in_ready", W'(in_ready), W'(cyc >= last_acc + N - 1));
    if (exp_lane.exists(cyc)) begin
      chk("R2 lane_data", W'(lane_data), W'(exp_lane[cyc]));
      chk("R2 lane_start", W'(lane_start), W'(exp_start[cyc]));
      chk("R9 lane_delta", W'(lane_delta), W'(exp_mode[cyc]));
    end else begin
      chk("R2 idle lanes", W'({lane_start, lane_data}), '0);
    end
    if (exp_out.exists(cyc)) begin
      chk("R10 out_valid", W'(out_valid), W'(1));
      chk("R5 R6 out_word", out_word, exp_out[cyc]);
    end else begin
      chk("R10 out_valid idle", W'(out_valid), '0);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] w, input logic d);
    logic take;
    logic [W-1:0] coded;
    in_valid = v;
    in_word  = w;
    delta_en = d;
    take = v && (cyc >= last_acc + N - 1);
    @(posedge clk);
    cyc++;
    if (take) begin
      coded = d ? (w - prev_word) : w;
      for (int k = 0; k < N; k++) begin
        exp_lane[cyc + k]  = coded[k*M +: M];
        exp_start[cyc + k] = (k == 0);
        exp_mode[cyc + k]  = d;
      end
      exp_out[cyc + N] = w;
      last_acc  = cyc;
      prev_word = w;
    end
    @(negedge clk);
    compare_now();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 in_ready", W'(in_ready), W'(1));
    chk("R1 out_valid", W'(out_valid), '0);
    chk("R1 lanes", W'({lane_start, lane_data}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_now();

    // R7: first delta word after reset goes out unchanged
    step(1'b1, 64'h0000_1000_0000_0040, 1'b1);
    step(1'b0, '0, 1'b1);
    // R6: sequential addresses in delta mode, back to back
    step(1'b1, 64'h0000_1000_0000_0080, 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b1, 64'h0000_1000_0000_00C0, 1'b1);
    // R4: offers while not ready are ignored
    step(1'b1, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0);
    step(1'b1, 64'h0000_1000_0000_0100, 1'b1);
    step(1'b1, 64'h1111_2222_3333_4444, 1'b1);
    // R5: raw words, several patterns
    step(1'b1, 64'hA5A5_5A5A_F0F0_0F0F, 1'b0);
    step(1'b0, '0, 1'b0);
    step(1'b1, 64'hFFFF_FFFF_0000_0001, 1'b0);
    step(1'b0, '0, 1'b0);
    // R8: delta word relative to the raw word just sent
    step(1'b1, 64'hFFFF_FFFF_0000_0011, 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    step(1'b0, '0, 1'b0);
    // R6: wraparound of the difference
    step(1'b1, 64'h0000_0000_0000_0000, 1'b1);
    // R9: mode flips during the transfer
    step(1'b0, '0, 1'b0);
    step(1'b1, 64'h0123_4567_89AB_CDEF, 1'b1);
    step(1'b1, 64'h0, 1'b0);
    step(1'b0, '0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 64'h0000_2000_0000_0000 + 64'(i * 8), 1'b1);
      step(1'b0, '0, 1'b1);
    end
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule